// File: doc/BRIEF.md
# Three-Stage Logic Pipeline with Operand Forwarding

This block is a compact in-order pipeline that executes a four-operation instruction set on a small register file: load an immediate into a register, bitwise AND of two registers, bitwise OR of two registers, and store (drive a register's value onto the output). Every cycle the environment presents one instruction. The first stage latches the instruction and resolves its two source operands. The second stage evaluates the logic function and fills a write-back register. The third stage commits the write-back register into the register file.

AND and OR never wait. Their operands are bypassed from the ALU result or the write-back register when an older instruction still in flight targets the same register. A store reads the register file directly with no bypass. A store whose register is still being produced by an instruction in stage one or stage two therefore raises a stall. While stall is high the environment must present the same instruction again in the next cycle, and the pipeline inserts an empty slot in its place. Register count and data width are parameters.

Top module: `logic_pipe3`

## Requirements
- R1: After reset, `stall_o` is low, `store_data_o` is zero, and every register reads as zero.
- R2: Opcodes on `op_i` are 2'b00 load, 2'b01 AND, 2'b10 OR and 2'b11 store. A load writes `imm_i` into register `dst_i`. An accepted store (stall low, op 2'b11) places register `dst_i` on `store_data_o` after the following rising clock edge.
- R3: AND and OR write the bitwise AND or OR of registers `src_a_i` and `src_b_i` into register `dst_i`.
- R4: An AND or OR accepted in the cycle right after a producer of one of its sources sees that producer's result. This holds when the producer is a load (its immediate) and when it is an AND or OR (its ALU result).
- R5: An AND or OR accepted two cycles after a producer of one of its sources sees that producer's result.
- R6: `stall_o` is high, in the same cycle as the inputs, exactly when `op_i` is store and `dst_i` equals the destination of a load, AND or OR accepted in either of the two previous cycles.
- R7: In a stalled cycle the instruction has no effect: `store_data_o` and the registers are unchanged. The re-presented instruction behaves as if issued later.
- R8: A store is never a producer: a store following a store to the same register does not stall. Load, AND and OR never stall.
- R9: `store_data_o` holds its value in every cycle without an accepted store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 2 | Opcode: 00 load, 01 AND, 10 OR, 11 store |
| imm_i | input | DW | Immediate for load |
| src_a_i | input | IW | First source register index |
| src_b_i | input | IW | Second source register index |
| dst_i | input | IW | Destination register (register read by store) |
| store_data_o | output | DW | Data of the last accepted store |
| stall_o | output | 1 | Re-present the current instruction next cycle |

## Verification
`stall_o` is combinational, so the bench drives each instruction on the falling edge and compares stall one time unit later, in the same cycle. `store_data_o` is registered and is due right after the rising edge that accepts a store. The bench compares it on every cycle just after that edge, against a single-cycle architectural model that updates its registers when an instruction is accepted. The model derives the expected stall from a two-deep history of accepted producer destinations. On a stall the bench re-presents the same instruction.

// File: rtl/lp3_pkg.sv
package lp3_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_AND   = 2'b01,
    OP_OR    = 2'b10,
    OP_STORE = 2'b11
  } op_e;

  function automatic logic is_producer(logic vld, op_e op);
    return vld && (op != OP_STORE);
  endfunction
endpackage

// File: rtl/lp3_regfile.sv
module lp3_regfile #(
  parameter int NREGS = 8,
  parameter int DW    = 16,
  parameter int NRD   = 3,
  localparam int IW   = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [IW-1:0]           waddr_i,
  input  logic [DW-1:0]           wdata_i,
  input  logic [NRD-1:0][IW-1:0]  raddr_i,
  output logic [NRD-1:0][DW-1:0]  rdata_o
);
  logic [DW-1:0] mem_q [NREGS];

  for (genvar k = 0; k < NREGS; k++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                mem_q[k] <= '0;
      else if (we_i && waddr_i == IW'(k))         mem_q[k] <= wdata_i;
    end

    a_r2_entry_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && waddr_i == IW'(k)) |=> (mem_q[k] == $past(wdata_i)));
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rdata_o[r] = mem_q[raddr_i[r]];
  end
endmodule

// File: rtl/lp3_fwd.sv
module lp3_fwd #(
  parameter int DW = 16,
  parameter int IW = 3
) (
  input  logic [IW-1:0] src_i,
  input  logic          s1_prod_i,
  input  logic          s1_load_i,
  input  logic [IW-1:0] s1_dst_i,
  input  logic [DW-1:0] s1_imm_i,
  input  logic [DW-1:0] alu_i,
  input  logic          s2_prod_i,
  input  logic [IW-1:0] s2_dst_i,
  input  logic [DW-1:0] wb_i,
  input  logic [DW-1:0] rf_i,
  output logic [DW-1:0] opnd_o
);
  // youngest producer wins
  always_comb begin
    if (s1_prod_i && src_i == s1_dst_i)      opnd_o = s1_load_i ? s1_imm_i : alu_i;
    else if (s2_prod_i && src_i == s2_dst_i) opnd_o = wb_i;
    else                                      opnd_o = rf_i;
  end
endmodule

// File: rtl/lp3_hazard.sv
module lp3_hazard #(
  parameter int IW  = 3,
  parameter int NST = 2
) (
  input  logic                   store_i,
  input  logic [IW-1:0]          dst_i,
  input  logic [NST-1:0]         prod_i,
  input  logic [NST-1:0][IW-1:0] pdst_i,
  output logic                   stall_o
);
  logic [NST-1:0] hit;
  for (genvar s = 0; s < NST; s++) begin : g_cmp
    assign hit[s] = prod_i[s] && (pdst_i[s] == dst_i);
  end
  assign stall_o = store_i && (|hit);
endmodule

// File: rtl/logic_pipe3.sv
module logic_pipe3
  import lp3_pkg::*;
#(
  parameter int NREGS = 8,
  parameter int DW    = 16,
  localparam int IW   = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    op_i,
  input  logic [DW-1:0] imm_i,
  input  logic [IW-1:0] src_a_i,
  input  logic [IW-1:0] src_b_i,
  input  logic [IW-1:0] dst_i,
  output logic [DW-1:0] store_data_o,
  output logic          stall_o
);
  localparam int NRD = 3;   // two operands + store read

  op_e op_in;
  assign op_in = op_e'(op_i);

  // stage one
  logic          s1_vld_q;
  op_e           s1_op_q;
  logic [IW-1:0] s1_dst_q;
  logic [DW-1:0] s1_imm_q;
  logic [1:0][DW-1:0] opnd_q, opnd_d;
  // stage two
  logic          s2_vld_q;
  op_e           s2_op_q;
  logic [IW-1:0] s2_dst_q;
  logic [DW-1:0] wb_q;
  logic [DW-1:0] store_q;

  logic s1_prod, s2_prod, stall;
  logic [DW-1:0] alu_res;
  logic [NRD-1:0][IW-1:0] raddr;
  logic [NRD-1:0][DW-1:0] rdata;

  assign s1_prod = is_producer(s1_vld_q, s1_op_q);
  assign s2_prod = is_producer(s2_vld_q, s2_op_q);
  assign alu_res = (s1_op_q == OP_AND) ? (opnd_q[0] & opnd_q[1])
                                       : (opnd_q[0] | opnd_q[1]);
  assign raddr   = {dst_i, src_b_i, src_a_i};

  lp3_regfile #(.NREGS(NREGS), .DW(DW), .NRD(NRD)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (s2_prod),
    .waddr_i (s2_dst_q),
    .wdata_i (wb_q),
    .raddr_i (raddr),
    .rdata_o (rdata)
  );

  for (genvar p = 0; p < 2; p++) begin : g_opnd
    lp3_fwd #(.DW(DW), .IW(IW)) u_fwd (
      .src_i     (raddr[p]),
      .s1_prod_i (s1_prod),
      .s1_load_i (s1_op_q == OP_LOAD),
      .s1_dst_i  (s1_dst_q),
      .s1_imm_i  (s1_imm_q),
      .alu_i     (alu_res),
      .s2_prod_i (s2_prod),
      .s2_dst_i  (s2_dst_q),
      .wb_i      (wb_q),
      .rf_i      (rdata[p]),
      .opnd_o    (opnd_d[p])
    );
  end

  lp3_hazard #(.IW(IW), .NST(2)) u_haz (
    .store_i (op_in == OP_STORE),
    .dst_i   (dst_i),
    .prod_i  ({s2_prod, s1_prod}),
    .pdst_i  ({s2_dst_q, s1_dst_q}),
    .stall_o (stall)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld_q <= 1'b0;
      s1_op_q  <= OP_LOAD;
      s1_dst_q <= '0;
      s1_imm_q <= '0;
      opnd_q   <= '0;
      s2_vld_q <= 1'b0;
      s2_op_q  <= OP_LOAD;
      s2_dst_q <= '0;
      wb_q     <= '0;
      store_q  <= '0;
    end else begin
      s1_vld_q <= !stall;           // bubble on stall
      s1_op_q  <= op_in;
      s1_dst_q <= dst_i;
      s1_imm_q <= imm_i;
      if (!stall) opnd_q <= opnd_d;
      s2_vld_q <= s1_vld_q;
      s2_op_q  <= s1_op_q;
      s2_dst_q <= s1_dst_q;
      if (s1_vld_q && (s1_op_q == OP_AND || s1_op_q == OP_OR)) wb_q <= alu_res;
      else if (s1_vld_q && s1_op_q == OP_LOAD)                   wb_q <= s1_imm_q;
      if (!stall && op_in == OP_STORE) store_q <= rdata[2];
    end
  end

  assign store_data_o = store_q;
  assign stall_o      = stall;

  a_r8_stall_only_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (op_i == 2'b11));
  a_r7_out_held_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> $stable(store_data_o));
  a_r7_bubble_inserted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> !s1_vld_q);
  a_r9_out_held_no_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i != 2'b11) |=> $stable(store_data_o));
  a_r2_wb_gets_imm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_vld_q && s1_op_q == OP_LOAD) |=> (wb_q == $past(s1_imm_q)));
endmodule

// File: tb/logic_pipe3_tb.sv
`timescale 1ns/1ps
module logic_pipe3_tb;
  localparam int NREGS = 8;
  localparam int DW    = 16;
  localparam int IW    = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    op = 2'b00;
  logic [DW-1:0] imm = '0;
  logic [IW-1:0] sa = '0, sb = '0, dst = 3'd7;
  logic [DW-1:0] store_data;
  logic          stall;

  always #5 clk = ~clk;

  logic_pipe3 #(.NREGS(NREGS), .DW(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .imm_i(imm),
    .src_a_i(sa), .src_b_i(sb), .dst_i(dst),
    .store_data_o(store_data), .stall_o(stall)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  string tag = "R1";

  logic [DW-1:0] ref_rf [NREGS];
  logic [DW-1:0] exp_out;
  int hist0 = -1, hist1 = -1;   // producer dst accepted 1 and 2 cycles ago

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // one instruction, replayed while the model expects a stall
  task automatic issue(logic [1:0] o, logic [DW-1:0] im, int a, int b, int d);
    bit exp_stall;
    do begin
      @(negedge clk);
      op = o; imm = im; sa = IW'(a); sb = IW'(b); dst = IW'(d);
      #1;
      exp_stall = (o == 2'b11) && ((hist0 == d) || (hist1 == d));
      chk(exp_stall ? "R6" : "R8", {15'd0, stall}, {15'd0, exp_stall});
      @(posedge clk);
      hist1 = hist0;
      if (exp_stall) hist0 = -1;
      else begin
        hist0 = (o == 2'b11) ? -1 : d;
        case (o)
          2'b00: ref_rf[d] = im;
          2'b01: ref_rf[d] = ref_rf[a] & ref_rf[b];
          2'b10: ref_rf[d] = ref_rf[a] | ref_rf[b];
          default: exp_out = ref_rf[d];
        endcase
      end
      #1;
      chk(exp_stall ? "R7" : tag, store_data, exp_out);
    end while (exp_stall);
  endtask

  task automatic fill(); issue(2'b00, 16'h0000, 0, 0, 7); endtask

  initial begin
    for (int i = 0; i < NREGS; i++) ref_rf[i] = '0;
    exp_out = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", store_data, 16'h0000);
    chk("R1", {15'd0, stall}, 16'h0000);
    @(negedge clk); rst_n = 1'b1;

    tag = "R1";
    for (int r = 0; r < NREGS; r++) issue(2'b11, 16'h0, 0, 0, r);

    tag = "R2";
    issue(2'b00, 16'h1234, 0, 0, 1);
    fill(); fill();
    issue(2'b11, 16'h0, 0, 0, 1);
    issue(2'b00, 16'hbeef, 0, 0, 2);   // R9: output must hold
    fill();

    tag = "R3";
    issue(2'b00, 16'h0f0f, 0, 0, 2);
    issue(2'b00, 16'h00ff, 0, 0, 3);
    fill(); fill(); fill();
    issue(2'b01, 16'h0, 2, 3, 4);
    issue(2'b10, 16'h0, 2, 3, 5);
    fill(); fill();
    issue(2'b11, 16'h0, 0, 0, 4);
    issue(2'b11, 16'h0, 0, 0, 5);

    tag = "R4";
    issue(2'b00, 16'ha5c3, 0, 0, 1);
    issue(2'b01, 16'h0, 1, 3, 2);      // load immediate forwarded
    issue(2'b10, 16'h0, 2, 4, 6);      // ALU result forwarded
    fill(); fill();
    issue(2'b11, 16'h0, 0, 0, 2);
    issue(2'b11, 16'h0, 0, 0, 6);

    tag = "R5";
    issue(2'b00, 16'h3c3c, 0, 0, 1);
    fill();
    issue(2'b10, 16'h0, 3, 1, 2);
    issue(2'b01, 16'h0, 2, 2, 0);
    fill();
    issue(2'b01, 16'h0, 5, 0, 3);
    fill(); fill();
    issue(2'b11, 16'h0, 0, 0, 2);
    issue(2'b11, 16'h0, 0, 0, 3);

    tag = "R6";
    issue(2'b00, 16'h7777, 0, 0, 6);
    issue(2'b11, 16'h0, 0, 0, 6);      // stalls twice
    issue(2'b01, 16'h0, 6, 6, 5);
    fill();
    issue(2'b11, 16'h0, 0, 0, 5);      // stalls once

    tag = "R8";
    issue(2'b11, 16'h0, 0, 0, 1);
    issue(2'b11, 16'h0, 0, 0, 1);
    issue(2'b00, 16'h1111, 0, 0, 1);
    issue(2'b00, 16'h2222, 0, 0, 1);
    issue(2'b11, 16'h0, 0, 0, 2);

    tag = "R9";
    for (int n = 0; n < 3000; n++) begin
      logic [1:0] o;
      o = 2'($urandom_range(0, 3));
      issue(o, 16'($urandom), $urandom_range(0, 7), $urandom_range(0, 7),
            $urandom_range(0, 7));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule